// File: doc/BRIEF.md
# Delay Line Length Auto-Tuner

This block calibrates a tapped clock delay line so that the line spans one period of its input clock. Software no longer runs the calibration loop. The block drives the delay controller's control fields directly: a sampling enable, a tap-select code and a unit-delay code with a write strobe. It reads back the controller's sampling-complete flag and its 12-bit length feedback vector.

A single-cycle `start_i` pulse begins a sweep. The tuner turns sampling on and selects all taps. It then writes unit-delay codes from 0 upward. After each write it waits for the sampling-complete flag and then judges the feedback vector. The sweep ends in one of three ways:
- **Success.** The feedback passes. The tuner raises `done_o` and keeps the number of delay units that fit in one period.
- **Too slow.** The code reaches its ceiling and the feedback still fails, which means the input clock is too slow. The tuner raises `fail_o`.
- **Timeout.** The flag does not arrive within a bounded wait. The tuner raises `fail_o` and sets `timeout_o`.

All pins are plain control and status signals. No stream or back-pressure handshake is involved, because the controller's write strobe is accepted unconditionally.

Top module: `dline_autotune`

## Requirements
- R1: During reset and right after it, `busy_o`, `done_o`, `fail_o`, `unit_wr_o`, `timeout_o` and `sample_en_o` are 0, and `tap_sel_o`, `unit_code_o` and `span_units_o` are 0.
- R2: When `start_i` is sampled high while idle, the next cycle shows `sample_en_o`=1, `tap_sel_o`=4'b1100 (all 12 taps), `unit_code_o`=0 and `unit_wr_o`=1. `sample_en_o` and `tap_sel_o` then hold.
- R3: `unit_wr_o` is a one-cycle strobe issued once per code value. After the strobe the tuner only waits, and it evaluates `feedback_i` only in a cycle where `feedback_valid_i` is high.
- R4: A feedback vector passes when it is nonzero and at least one of bits 11 and 10 is 0. On a pass, `done_o` pulses in the cycle after the flag is sampled.
- R5: On a failing vector below code 127, the cycle after the flag shows `unit_code_o` one higher together with a new `unit_wr_o` strobe.
- R6: A failing vector at code 127 gives a `fail_o` pulse with `timeout_o`=0 and `unit_code_o` left at 127.
- R7: On success, `span_units_o` holds the index of the highest set feedback bit plus one (1 to 12) until the next sweep ends. On any failure it becomes 0.
- R8: If `feedback_valid_i` stays low for `TIMEOUT_CYC` cycles after a strobe, `fail_o` pulses and `timeout_o` is set to 1. `timeout_o` holds until the next sweep ends.
- R9: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` or `fail_o` pulses, and it is low in that cycle. `done_o` and `fail_o` last one cycle each and never coincide.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The sweep continues without a code reset or an extra strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a tuning sweep |
| feedback_valid_i | input | 1 | Controller's sampling-complete flag |
| feedback_i | input | 12 | Controller's delay length feedback vector |
| sample_en_o | output | 1 | Length sampling enable to the controller |
| tap_sel_o | output | 4 | Tap-select code to the controller |
| unit_code_o | output | 7 | Unit-delay code to the controller; holds the final code |
| unit_wr_o | output | 1 | Write strobe for the unit-delay code (starts a sampling) |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| timeout_o | output | 1 | Last sweep failed because the flag never arrived |
| span_units_o | output | 4 | Delay units in one input period (0 after a failure) |

## Verification
The sweep is driven by an emulated controller that answers each code strobe after a short latency. Five feedback profiles are used, and each one isolates a different decision:
- **All-ones below code 5, then 0x7FF.** Separates the "both top bits set" failure from a pass. It also exercises the step-and-rewrite path several times.
- **Zero vectors, then 0xC00, then 0x800.** Shows that an all-zero vector fails and that a single top bit gives 12 units.
- **Always all-ones.** Drives the code to 127 and exposes the too-slow exit.
- **A silent controller.** Exposes the timeout exit.
- **0x001 at code 0.** Gives the smallest span and shows that the timeout flag clears on a later success.

A second start is injected in the middle of one sweep to show that it has no effect on the code sequence.

// File: rtl/dline_tune_pkg.sv
package dline_tune_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WAIT  = 2'd2
  } tune_state_t;
endpackage

// File: rtl/dline_span_enc.sv
module dline_span_enc #(
  parameter int TAPS   = 12,
  parameter int SPAN_W = 4
) (
  input  logic [TAPS-1:0]   vec_i,
  output logic              pass_o,
  output logic [SPAN_W-1:0] span_o
);
  logic [TAPS-1:0] hit;

  // hit[i] marks bit i as the highest set bit
  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_hit
      if (g == TAPS - 1) begin : g_top
        assign hit[g] = vec_i[g];
      end else begin : g_low
        assign hit[g] = vec_i[g] && (vec_i[TAPS-1:g+1] == '0);
      end
    end
  endgenerate

  always_comb begin
    span_o = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (hit[i]) span_o = SPAN_W'(i + 1);
    end
  end

  // line spans a period: something sampled and the two last taps not both reached
  assign pass_o = (|vec_i) && !(&vec_i[TAPS-1 -: 2]);
endmodule

// File: rtl/dline_wait_timer.sv
module dline_wait_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (!expired_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign expired_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/dline_seq_fsm.sv
module dline_seq_fsm
  import dline_tune_pkg::*;
#(
  parameter int TAPS   = 12,
  parameter int UNIT_W = 7,
  parameter int SEL_W  = 4,
  parameter int SPAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fb_valid_i,
  input  logic              pass_i,
  input  logic [SPAN_W-1:0] span_i,
  input  logic              expired_i,
  output logic              waiting_o,
  output logic              sample_en_o,
  output logic [SEL_W-1:0]  tap_sel_o,
  output logic [UNIT_W-1:0] unit_code_o,
  output logic              unit_wr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              timeout_o,
  output logic [SPAN_W-1:0] span_o
);
  localparam logic [UNIT_W-1:0] UNIT_MAX = {UNIT_W{1'b1}};
  localparam logic [SEL_W-1:0]  SEL_ALL  = SEL_W'(TAPS);

  tune_state_t      state_q;
  logic             sen_q, done_q, fail_q, tmo_q;
  logic [SEL_W-1:0] sel_q;
  logic [UNIT_W-1:0] unit_q;
  logic [SPAN_W-1:0] span_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sen_q   <= 1'b0;
      sel_q   <= '0;
      unit_q  <= '0;
      span_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sen_q   <= 1'b1;
            sel_q   <= SEL_ALL;
            unit_q  <= '0;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fb_valid_i) begin
            if (pass_i) begin
              done_q  <= 1'b1;
              span_q  <= span_i;
              tmo_q   <= 1'b0;
              state_q <= ST_IDLE;
            end else if (unit_q == UNIT_MAX) begin
              fail_q  <= 1'b1;
              span_q  <= '0;
              tmo_q   <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              unit_q  <= unit_q + UNIT_W'(1);
              state_q <= ST_WRITE;
            end
          end else if (expired_i) begin
            fail_q  <= 1'b1;
            span_q  <= '0;
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign waiting_o   = (state_q == ST_WAIT);
  assign unit_wr_o   = (state_q == ST_WRITE);
  assign busy_o      = (state_q != ST_IDLE);
  assign sample_en_o = sen_q;
  assign tap_sel_o   = sel_q;
  assign unit_code_o = unit_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign timeout_o   = tmo_q;
  assign span_o      = span_q;
endmodule

// File: rtl/dline_autotune.sv
module dline_autotune #(
  parameter int TAPS        = 12,
  parameter int UNIT_W      = 7,
  parameter int SEL_W       = 4,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        feedback_valid_i,
  input  logic [TAPS-1:0]             feedback_i,
  output logic                        sample_en_o,
  output logic [SEL_W-1:0]            tap_sel_o,
  output logic [UNIT_W-1:0]           unit_code_o,
  output logic                        unit_wr_o,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        fail_o,
  output logic                        timeout_o,
  output logic [$clog2(TAPS+1)-1:0]   span_units_o
);
  localparam int SPAN_W = $clog2(TAPS + 1);

  logic              pass_w;
  logic [SPAN_W-1:0] span_w;
  logic              waiting_w;
  logic              expired_w;

  dline_span_enc #(.TAPS(TAPS), .SPAN_W(SPAN_W)) u_enc (
    .vec_i  (feedback_i),
    .pass_o (pass_w),
    .span_o (span_w)
  );

  dline_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (waiting_w),
    .expired_o (expired_w)
  );

  dline_seq_fsm #(
    .TAPS(TAPS), .UNIT_W(UNIT_W), .SEL_W(SEL_W), .SPAN_W(SPAN_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .fb_valid_i  (feedback_valid_i),
    .pass_i      (pass_w),
    .span_i      (span_w),
    .expired_i   (expired_w),
    .waiting_o   (waiting_w),
    .sample_en_o (sample_en_o),
    .tap_sel_o   (tap_sel_o),
    .unit_code_o (unit_code_o),
    .unit_wr_o   (unit_wr_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .timeout_o   (timeout_o),
    .span_o      (span_units_o)
  );
endmodule

// File: rtl/dline_autotune_chk.sv
module dline_autotune_chk #(
  parameter int TAPS   = 12,
  parameter int UNIT_W = 7,
  parameter int SEL_W  = 4,
  parameter int SPAN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              sample_en_o,
  input logic [SEL_W-1:0]  tap_sel_o,
  input logic [UNIT_W-1:0] unit_code_o,
  input logic              unit_wr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              timeout_o,
  input logic [SPAN_W-1:0] span_units_o
);
  // R9
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  // R9
  idle_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |-> !busy_o);

  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_wr_o |=> !unit_wr_o);

  // R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$stable(unit_code_o))
      |-> (unit_wr_o && unit_code_o == $past(unit_code_o) + UNIT_W'(1)));

  // R2
  start_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (sample_en_o && tap_sel_o == SEL_W'(TAPS)
                             && unit_code_o == '0 && unit_wr_o));

  // R6
  too_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !timeout_o) |-> (unit_code_o == {UNIT_W{1'b1}}));

  // R7
  span_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (span_units_o != '0 && span_units_o <= SPAN_W'(TAPS)));

  // R7
  span_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (span_units_o == '0));
endmodule

bind dline_autotune dline_autotune_chk #(
  .TAPS(TAPS), .UNIT_W(UNIT_W), .SEL_W(SEL_W), .SPAN_W($clog2(TAPS+1))
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .sample_en_o  (sample_en_o),
  .tap_sel_o    (tap_sel_o),
  .unit_code_o  (unit_code_o),
  .unit_wr_o    (unit_wr_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .timeout_o    (timeout_o),
  .span_units_o (span_units_o)
);

// File: tb/dline_autotune_test.sv
module dline_autotune_test;
  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        fb_valid = 1'b0;
  logic [11:0] fb = '0;
  logic        sample_en_o, unit_wr_o, busy_o, done_o, fail_o, timeout_o;
  logic [3:0]  tap_sel_o, span_units_o;
  logic [6:0]  unit_code_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  dline_autotune #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .feedback_valid_i(fb_valid), .feedback_i(fb),
    .sample_en_o(sample_en_o), .tap_sel_o(tap_sel_o),
    .unit_code_o(unit_code_o), .unit_wr_o(unit_wr_o),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .timeout_o(timeout_o), .span_units_o(span_units_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // emulated controller profiles
  int scen = 0;
  bit resp_en = 1'b1;
  int cd = 0;

  function automatic logic [11:0] lng_for(int s, int u);
    case (s)
      1: return (u < 5) ? 12'hFFF : 12'h7FF;
      2: return (u < 2) ? 12'h000 : (u == 2) ? 12'hC00 : 12'h800;
      3: return 12'hFFF;
      default: return 12'h001;
    endcase
  endfunction

  function automatic bit ref_pass(logic [11:0] v);
    return (v != 0) && !(v[11] && v[10]);
  endfunction

  function automatic int ref_span(logic [11:0] v);
    for (int i = 11; i >= 0; i--) if (v[i]) return i + 1;
    return 0;
  endfunction

  // behavioural reference model, advanced on each rising edge
  int  m_mode = 0;  // 0 idle, 1 strobe, 2 waiting
  int  m_unit = 0, m_wait = 0, m_span = 0, m_sel = 0;
  bit  m_sen = 0, m_done = 0, m_fail = 0, m_tmo = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 0;
      m_fail = 0;
      if (m_mode == 0) begin
        if (start_i) begin
          m_mode = 1; m_unit = 0; m_sen = 1; m_sel = 12;
        end
      end else if (m_mode == 1) begin
        m_mode = 2; m_wait = 0;
      end else begin
        if (fb_valid) begin
          if (ref_pass(fb)) begin
            m_done = 1; m_span = ref_span(fb); m_tmo = 0; m_mode = 0;
          end else if (m_unit == 127) begin
            m_fail = 1; m_span = 0; m_tmo = 0; m_mode = 0;
          end else begin
            m_unit++; m_mode = 1;
          end
        end else if (m_wait == TMO - 1) begin
          m_fail = 1; m_span = 0; m_tmo = 1; m_mode = 0;
        end else begin
          m_wait++;
        end
      end
    end
  end

  // compare every cycle, then drive the emulated controller
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(busy_o == (m_mode != 0), "R9 busy", busy_o, m_mode != 0);
      chk(done_o == m_done, "R4 done", done_o, m_done);
      chk(fail_o == m_fail, "R9 fail", fail_o, m_fail);
      chk(unit_wr_o == (m_mode == 1), "R3 strobe", unit_wr_o, m_mode == 1);
      chk(unit_code_o == m_unit, "R5 unit", unit_code_o, m_unit);
      chk(span_units_o == m_span, "R7 span", span_units_o, m_span);
      chk(timeout_o == m_tmo, "R8 timeout", timeout_o, m_tmo);
      chk(sample_en_o == m_sen, "R2 sen", sample_en_o, m_sen);
      chk(tap_sel_o == m_sel, "R2 sel", tap_sel_o, m_sel);
      fb_valid <= 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          fb_valid <= 1'b1;
          fb <= lng_for(scen, unit_code_o);
        end
      end
      if (unit_wr_o && resp_en) cd = 2;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    finish_run();
  end

  task automatic run(input int s, input bit resp, input bit poke_busy);
    int n = 0;
    scen = s;
    resp_en = resp;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (!(done_o || fail_o) && n < 2000) begin
      n++;
      if (poke_busy && n == 7) start_i = 1'b1;  // R10 start while busy
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !fail_o && !unit_wr_o && !timeout_o, "R1 flags", busy_o, 0);
    chk(!sample_en_o && tap_sel_o == 0 && unit_code_o == 0 && span_units_o == 0,
        "R1 fields", unit_code_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(1, 1, 1);  // R4 R10
    chk(done_o, "R4 profile1 done", done_o, 1);
    chk(unit_code_o == 5, "R10 code not restarted", unit_code_o, 5);
    chk(span_units_o == 11, "R7 span 11", span_units_o, 11);
    repeat (3) @(negedge clk);

    run(2, 1, 0);
    chk(done_o && unit_code_o == 3, "R4 zero vector fails", unit_code_o, 3);
    chk(span_units_o == 12, "R7 span 12", span_units_o, 12);

    run(3, 1, 0);
    chk(fail_o && !timeout_o, "R6 too slow", timeout_o, 0);
    chk(unit_code_o == 127, "R6 ceiling", unit_code_o, 127);
    chk(span_units_o == 0, "R7 cleared", span_units_o, 0);

    run(4, 0, 0);
    chk(fail_o && timeout_o, "R8 timeout set", timeout_o, 1);
    chk(unit_code_o == 0, "R8 at code 0", unit_code_o, 0);
    repeat (5) @(negedge clk);
    chk(timeout_o, "R8 timeout holds", timeout_o, 1);

    run(5, 1, 0);
    chk(done_o && span_units_o == 1, "R7 span 1", span_units_o, 1);
    chk(!timeout_o, "R8 cleared by success", timeout_o, 0);
    @(negedge clk);
    chk(!done_o && !busy_o, "R9 single pulse", done_o, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule